// File: doc/BRIEF.md
# Row-Sliding Image Window Buffer

This block feeds a convolution engine from a 28×28 grayscale image held in a dual-ported image memory. It keeps a six-row band of the image on chip, covering all 28 columns. Once the band is complete, it plays the band out as vertical six-pixel columns, one per cycle, with no gaps. The engine therefore never has to wait for the memory, which can only supply two pixels per cycle.

After reset the block requests image rows 0 to 5 on its own, two horizontally adjacent pixels per request. It then streams columns 0 to 27 and waits. A slide command moves the band two rows further down the image. The four lower rows move up inside the storage, so only the two new bottom rows have to be fetched. That takes 28 requests instead of 84. There are twelve band positions in all, with top rows 0, 2, …, 22. After the last position has been streamed, the block reports that the image is finished and stays in that state until reset.

Top module: `row_slide_window`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the band storage, counters and flags. After reset, `window_ready`, `col_valid`, `col_done` and `image_done` are low and `win_top` is 0. `fetch_req` is high and requests row 0, column 0.
- R2: The initial fill requests image rows 0 to 5 in that order. Each row is requested as 14 pixel pairs, left to right, and `fetch_col` is the even column of the pair. `fetch_data[7:0]` holds the pixel at that column and `fetch_data[15:8]` the pixel at the next column. A request is consumed at every clock edge where `fetch_vld` is high.
- R3: `window_ready` and `col_valid` rise in the cycle after the last fetch of a fill is consumed. `col_valid` then stays high for 28 consecutive cycles while `col_idx` counts 0 to 27.
- R4: While `col_valid` is high, byte k of `col_data` (bits 8k+7:8k, k = 0..5) equals the image pixel at row `win_top`+k and column `col_idx`.
- R5: `col_done` goes high in the cycle after column 27 is shown. It holds, with `col_valid` low, until a slide is accepted.
- R6: A `slide` pulse while `col_done` is high and `image_done` is low is accepted. In the next cycle `win_top` has grown by 2, `window_ready` and `col_done` are low, and the block requests image rows `win_top`+4 and then `win_top`+5, 28 pairs in all. The band is then streamed again.
- R7: `slide` while `col_done` is low has no effect: the fetch sequence, the stream timing and the column data are unchanged.
- R8: While `fetch_vld` is low, `fetch_req`, `fetch_row` and `fetch_col` hold their values.
- R9: After the band with `win_top` = 22 has been streamed, `image_done` and `col_done` go high together and stay high. No further fetch is requested, and `slide` is ignored: `win_top` stays 22.
- R10: A reset in the middle of an image returns the block to the state of R1, and a full image then runs correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | output | 1 | A pixel pair is being requested |
| fetch_row | output | 5 | Image row of the requested pair |
| fetch_col | output | 5 | Even image column of the requested pair |
| fetch_data | input | 16 | Pixel pair: low byte at fetch_col, high byte at fetch_col+1 |
| fetch_vld | input | 1 | fetch_data is valid; the request is consumed at this edge |
| slide | input | 1 | Move the band down by two rows |
| window_ready | output | 1 | The band holds six complete rows |
| col_valid | output | 1 | col_data and col_idx carry a column |
| col_idx | output | 5 | Column index being shown |
| col_data | output | 48 | Six pixels of the column, band row 0 in the low byte |
| col_done | output | 1 | All 28 columns of the current band have been shown |
| image_done | output | 1 | The last band position has been streamed |
| win_top | output | 5 | Image row held in band row 0 |

## Verification
Every output comes straight from registered state, so each response appears exactly one clock edge after the input that caused it. A consumed fetch moves the requested address one cycle later. The 84th or 28th consumed fetch makes the first column visible one cycle later. An accepted slide changes `win_top` and restarts fetching one cycle later. The bench drives inputs on the falling edge and compares outputs on the next falling edge, against a cycle model written from the requirements. Because of this, a response one cycle early or late is reported as a mismatch. Complete images are swept under several pixel seeds, with memory stalls, with stray slides and with varying delays before each slide.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
    typedef enum logic [1:0] {
        PH_FILL   = 2'd0,
        PH_STREAM = 2'd1,
        PH_HOLD   = 2'd2,
        PH_END    = 2'd3
    } rsw_phase_e;

    localparam int PIX_PER_FETCH = 2;
endpackage

// File: rtl/rsw_store.sv
module rsw_store
    import rsw_pkg::*;
#(
    parameter  int ROWS      = 6,
    parameter  int COLS      = 28,
    parameter  int PIX_W     = 8,
    parameter  int STEP      = 2,
    localparam int PAIRS     = COLS / PIX_PER_FETCH,
    localparam int FETCH_W   = PIX_PER_FETCH * PIX_W,
    localparam int ROW_IDX_W = $clog2(ROWS),
    localparam int PAIR_W    = $clog2(PAIRS),
    localparam int COL_W     = $clog2(COLS),
    localparam int ROW_BITS  = COLS * PIX_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ROW_IDX_W-1:0]    wr_row,
    input  logic [PAIR_W-1:0]       wr_pair,
    input  logic [FETCH_W-1:0]      wr_data,
    input  logic                    shift_en,
    input  logic [COL_W-1:0]        rd_col,
    output logic [ROWS*PIX_W-1:0]   rd_data
);
    logic [ROWS-1:0][ROW_BITS-1:0] rows_w;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [ROW_BITS-1:0] row_d, row_q, up_w;
        logic [PIX_W-1:0]    sel_w;

        // Lower rows take the row STEP below them; bottom rows keep their data.
        if (r < ROWS - STEP) begin : g_shift
            assign up_w = rows_w[r+STEP];
        end else begin : g_keep
            assign up_w = row_q;
        end

        always_comb begin
            row_d = row_q;
            if (shift_en) begin
                row_d = up_w;
            end else if (wr_en && wr_row == ROW_IDX_W'(r)) begin
                for (int p = 0; p < PAIRS; p++) begin
                    if (wr_pair == PAIR_W'(p)) begin
                        row_d[p*FETCH_W +: FETCH_W] = wr_data;
                    end
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) row_q <= '0;
            else     row_q <= row_d;
        end

        always_comb begin
            sel_w = '0;
            for (int c = 0; c < COLS; c++) begin
                if (rd_col == COL_W'(c)) sel_w = row_q[c*PIX_W +: PIX_W];
            end
        end

        assign rows_w[r]                   = row_q;
        assign rd_data[r*PIX_W +: PIX_W]   = sel_w;
    end
endmodule

// File: rtl/rsw_ctrl.sv
module rsw_ctrl
    import rsw_pkg::*;
#(
    parameter  int IMG_H     = 28,
    parameter  int ROWS      = 6,
    parameter  int COLS      = 28,
    parameter  int STEP      = 2,
    localparam int PAIRS     = COLS / PIX_PER_FETCH,
    localparam int LAST_TOP  = IMG_H - ROWS,
    localparam int TOP_W     = $clog2(IMG_H),
    localparam int ROW_IDX_W = $clog2(ROWS),
    localparam int PAIR_W    = $clog2(PAIRS),
    localparam int COL_W     = $clog2(COLS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fetch_vld,
    input  logic                 slide,
    output logic                 fetch_req,
    output logic [TOP_W-1:0]     fetch_row,
    output logic [COL_W-1:0]     fetch_col,
    output logic                 wr_en,
    output logic [ROW_IDX_W-1:0] wr_row,
    output logic [PAIR_W-1:0]    wr_pair,
    output logic                 shift_en,
    output logic [COL_W-1:0]     rd_col,
    output logic                 col_valid,
    output logic                 col_done,
    output logic                 window_ready,
    output logic                 image_done,
    output logic [TOP_W-1:0]     win_top
);
    typedef struct packed {
        rsw_phase_e           phase;
        logic [TOP_W-1:0]     top;
        logic [ROW_IDX_W-1:0] wrow;
        logic [PAIR_W-1:0]    pair;
        logic [COL_W-1:0]     col;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{phase: PH_FILL, top: '0, wrow: '0, pair: '0, col: '0};

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        wr_en    = 1'b0;
        shift_en = 1'b0;
        case (ctl_q.phase)
            PH_FILL: begin
                if (fetch_vld) begin
                    wr_en = 1'b1;
                    if (ctl_q.pair == PAIR_W'(PAIRS - 1)) begin
                        ctl_d.pair = '0;
                        if (ctl_q.wrow == ROW_IDX_W'(ROWS - 1)) begin
                            ctl_d.phase = PH_STREAM;
                            ctl_d.col   = '0;
                        end else begin
                            ctl_d.wrow = ctl_q.wrow + 1'b1;
                        end
                    end else begin
                        ctl_d.pair = ctl_q.pair + 1'b1;
                    end
                end
            end
            PH_STREAM: begin
                if (ctl_q.col == COL_W'(COLS - 1)) begin
                    ctl_d.col   = '0;
                    ctl_d.phase = (ctl_q.top == TOP_W'(LAST_TOP)) ? PH_END : PH_HOLD;
                end else begin
                    ctl_d.col = ctl_q.col + 1'b1;
                end
            end
            PH_HOLD: begin
                if (slide) begin
                    shift_en    = 1'b1;
                    ctl_d.top   = ctl_q.top + TOP_W'(STEP);
                    ctl_d.wrow  = ROW_IDX_W'(ROWS - STEP);
                    ctl_d.pair  = '0;
                    ctl_d.phase = PH_FILL;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTRL_RST;
        else     ctl_q <= ctl_d;
    end

    assign fetch_req    = (ctl_q.phase == PH_FILL);
    assign fetch_row    = ctl_q.top + TOP_W'(ctl_q.wrow);
    assign fetch_col    = COL_W'({ctl_q.pair, 1'b0});
    assign wr_row       = ctl_q.wrow;
    assign wr_pair      = ctl_q.pair;
    assign rd_col       = ctl_q.col;
    assign col_valid    = (ctl_q.phase == PH_STREAM);
    assign col_done     = (ctl_q.phase == PH_HOLD) || (ctl_q.phase == PH_END);
    assign window_ready = (ctl_q.phase != PH_FILL);
    assign image_done   = (ctl_q.phase == PH_END);
    assign win_top      = ctl_q.top;
endmodule

// File: rtl/row_slide_window.sv
module row_slide_window
    import rsw_pkg::*;
#(
    parameter  int IMG_W    = 28,
    parameter  int IMG_H    = 28,
    parameter  int WIN_ROWS = 6,
    parameter  int STEP     = 2,
    parameter  int PIX_W    = 8,
    localparam int ROW_W    = $clog2(IMG_H),
    localparam int COL_W    = $clog2(IMG_W),
    localparam int FETCH_W  = PIX_PER_FETCH * PIX_W,
    localparam int OUT_W    = WIN_ROWS * PIX_W,
    localparam int RIDX_W   = $clog2(WIN_ROWS),
    localparam int PAIR_W   = $clog2(IMG_W / PIX_PER_FETCH)
) (
    input  logic               clk,
    input  logic               rst,
    output logic               fetch_req,
    output logic [ROW_W-1:0]   fetch_row,
    output logic [COL_W-1:0]   fetch_col,
    input  logic [FETCH_W-1:0] fetch_data,
    input  logic               fetch_vld,
    input  logic               slide,
    output logic               window_ready,
    output logic               col_valid,
    output logic [COL_W-1:0]   col_idx,
    output logic [OUT_W-1:0]   col_data,
    output logic               col_done,
    output logic               image_done,
    output logic [ROW_W-1:0]   win_top
);
    logic              wr_en, shift_en;
    logic [RIDX_W-1:0] wr_row;
    logic [PAIR_W-1:0] wr_pair;

    rsw_ctrl #(
        .IMG_H(IMG_H), .ROWS(WIN_ROWS), .COLS(IMG_W), .STEP(STEP)
    ) u_ctrl (
        .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .slide(slide),
        .fetch_req(fetch_req), .fetch_row(fetch_row), .fetch_col(fetch_col),
        .wr_en(wr_en), .wr_row(wr_row), .wr_pair(wr_pair), .shift_en(shift_en),
        .rd_col(col_idx), .col_valid(col_valid), .col_done(col_done),
        .window_ready(window_ready), .image_done(image_done), .win_top(win_top)
    );

    rsw_store #(
        .ROWS(WIN_ROWS), .COLS(IMG_W), .PIX_W(PIX_W), .STEP(STEP)
    ) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_pair(wr_pair),
        .wr_data(fetch_data), .shift_en(shift_en), .rd_col(col_idx), .rd_data(col_data)
    );
endmodule

// File: rtl/rsw_chk.sv
module rsw_chk #(
    parameter  int IMG_W    = 28,
    parameter  int IMG_H    = 28,
    parameter  int WIN_ROWS = 6,
    localparam int ROW_W    = $clog2(IMG_H),
    localparam int COL_W    = $clog2(IMG_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             fetch_req,
    input logic             fetch_vld,
    input logic [ROW_W-1:0] fetch_row,
    input logic [COL_W-1:0] fetch_col,
    input logic             slide,
    input logic             window_ready,
    input logic             col_valid,
    input logic [COL_W-1:0] col_idx,
    input logic             col_done,
    input logic             image_done,
    input logic [ROW_W-1:0] win_top
);
    // R3
    stream_ready_chk: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> window_ready);

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (col_valid && col_idx != COL_W'(IMG_W - 1)) |=>
        (col_valid && col_idx == $past(col_idx) + 1'b1));

    // R5
    last_col_done_chk: assert property (@(posedge clk) disable iff (rst)
        (col_valid && col_idx == COL_W'(IMG_W - 1)) |=> col_done);

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (col_done && !image_done && !slide) |=> (col_done && !col_valid));

    // R7
    top_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(col_done && slide) |=> $stable(win_top));

    // R6
    slide_refill_chk: assert property (@(posedge clk) disable iff (rst)
        (col_done && slide && !image_done) |=>
        (fetch_req && !window_ready && fetch_row == $past(win_top) + ROW_W'(WIN_ROWS)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_vld) |=> (fetch_req && $stable(fetch_row) && $stable(fetch_col)));

    // R9
    end_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        image_done |=> (image_done && col_done && !fetch_req));

    // R2
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fetch_req, col_valid, col_done}));
endmodule

bind row_slide_window rsw_chk #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .WIN_ROWS(WIN_ROWS)
) u_rsw_chk (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_vld(fetch_vld),
    .fetch_row(fetch_row), .fetch_col(fetch_col), .slide(slide),
    .window_ready(window_ready), .col_valid(col_valid), .col_idx(col_idx),
    .col_done(col_done), .image_done(image_done), .win_top(win_top)
);

// File: tb/tb_row_slide_window.sv
`timescale 1ns/1ps
module tb_row_slide_window;
    localparam int W = 28;
    localparam int H = 28;
    localparam int R = 6;
    localparam int LAST = H - R;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req, fetch_vld = 1'b0, slide = 1'b0;
    logic [4:0]  fetch_row, fetch_col, col_idx, win_top;
    logic [15:0] fetch_data;
    logic        window_ready, col_valid, col_done, image_done;
    logic [47:0] col_data;

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0, seed = 0;
    logic [7:0] lfsr = 8'h5A;
    bit finished = 1'b0;
    int m_ph, m_top, m_row, m_pair, m_col, hold_cnt;

    function automatic logic [7:0] pix(input int r, input int c);
        return 8'(r * 29 + c * 7 + seed * 13 + 1);
    endfunction

    assign fetch_data = {pix(int'(fetch_row), int'(fetch_col) + 1), pix(int'(fetch_row), int'(fetch_col))};

    row_slide_window dut (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_row(fetch_row),
        .fetch_col(fetch_col), .fetch_data(fetch_data), .fetch_vld(fetch_vld),
        .slide(slide), .window_ready(window_ready), .col_valid(col_valid),
        .col_idx(col_idx), .col_data(col_data), .col_done(col_done),
        .image_done(image_done), .win_top(win_top)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // R1 / R10: reset state at the ports
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; slide = 1'b0; fetch_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(window_ready == 1'b0, tag, window_ready, 0);
        chk(col_valid == 1'b0,    tag, col_valid, 0);
        chk(col_done == 1'b0,     tag, col_done, 0);
        chk(image_done == 1'b0,   tag, image_done, 0);
        chk(win_top == 5'd0,      tag, win_top, 0);
        chk(fetch_req == 1'b1,    tag, fetch_req, 1);
        chk(fetch_row == 5'd0,    tag, fetch_row, 0);
        chk(fetch_col == 5'd0,    tag, fetch_col, 0);
        m_ph = 0; m_top = 0; m_row = 0; m_pair = 0; m_col = 0; hold_cnt = 0;
    endtask

    task automatic step(input bit stall, input bit inject, input int hold_n);
        // compare outputs against the cycle model
        chk(int'(win_top) == m_top, "R6 win_top", win_top, m_top);
        chk(fetch_req == (m_ph == 0), "R2 fetch_req", fetch_req, m_ph == 0);
        chk(window_ready == (m_ph != 0), "R3 window_ready", window_ready, m_ph != 0);
        chk(col_valid == (m_ph == 1), "R3 col_valid", col_valid, m_ph == 1);
        chk(col_done == (m_ph >= 2), "R5 col_done", col_done, m_ph >= 2);
        chk(image_done == (m_ph == 3), "R9 image_done", image_done, m_ph == 3);
        if (m_ph == 0) begin
            chk(int'(fetch_row) == m_top + m_row, "R2 fetch_row", fetch_row, m_top + m_row);
            chk(int'(fetch_col) == 2 * m_pair, "R2 fetch_col", fetch_col, 2 * m_pair);
        end
        if (m_ph == 1) begin
            chk(int'(col_idx) == m_col, "R3 col_idx", col_idx, m_col);
            for (int k = 0; k < R; k++) begin
                chk(col_data[k*8 +: 8] == pix(m_top + k, m_col), "R4 col_data byte",
                    col_data[k*8 +: 8], pix(m_top + k, m_col));
            end
        end
        // choose inputs for the coming edge (R7 stray slides, R8 stalls)
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        fetch_vld = stall ? (lfsr[0] | lfsr[1]) : 1'b1;
        if (m_ph == 2)      slide = (hold_cnt >= hold_n);
        else if (m_ph == 3) slide = 1'b1;
        else                slide = inject & lfsr[2];
        // advance the model across the edge
        case (m_ph)
            0: if (fetch_vld) begin
                if (m_pair == W / 2 - 1) begin
                    m_pair = 0;
                    if (m_row == R - 1) begin m_ph = 1; m_col = 0; end
                    else m_row++;
                end else m_pair++;
            end
            1: if (m_col == W - 1) begin
                m_col = 0; hold_cnt = 0;
                m_ph = (m_top == LAST) ? 3 : 2;
            end else m_col++;
            2: if (slide) begin
                m_top += 2; m_row = R - 2; m_pair = 0; m_ph = 0;
            end else hold_cnt++;
            default: ;
        endcase
        @(negedge clk);
    endtask

    task automatic run_image(input bit stall, input bit inject, input int hold_n, input int abort_at);
        int cyc = 0;
        int end_cnt = 0;
        while (end_cnt < 5) begin
            if (cyc == abort_at) begin
                seed++;
                do_reset("R10");
            end
            if (m_ph == 3) end_cnt++;
            step(stall, inject, hold_n);
            cyc++;
        end
        chk(int'(win_top) == LAST, "R9 final top", win_top, LAST);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            summary();
            $finish;
        end
    end

    initial begin
        seed = 1; do_reset("R1");
        run_image(1'b0, 1'b0, 0, -1);
        seed = 2; do_reset("R1");
        run_image(1'b1, 1'b1, 3, -1);
        seed = 5; do_reset("R1");
        run_image(1'b0, 1'b1, 1, -1);
        seed = 7; do_reset("R1");
        run_image(1'b1, 1'b0, 2, 300);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule